// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Full-Duty Override

This block is one channel of a general-purpose timer. It owns a free-running up-counter that wraps to zero after reaching a programmable modulus. The channel runs in one of two families of modes. In capture mode it stores the counter value when a chosen edge arrives on an external input. In compare mode it watches for the counter to equal a stored 16-bit value and acts on an output pin. With toggle-on-wrap enabled, compare mode produces a pulse-width-modulated waveform whose period is set by the modulus and whose duty is set by the stored value.

Software reaches the 16-bit channel value over an 8-bit bus, one byte at a time. Touching the upper byte suspends the channel's own updates until the lower byte is touched as well, so that software never sees a torn 16-bit value. Captures are suspended after a read of the upper byte, and compares after a write to it. A full-duty override bit holds the waveform at its active level for whole periods. The override is sampled only when the counter wraps, so it starts and stops on period boundaries and never clips a pulse.

Top module: `tim_chan`

## Requirements
- R1: The counter `cnt_o` is 0 after reset and advances by one per clock. When it equals `modulus_i` it becomes 0 on the next clock. That cycle is the wrap event.
- R2: With `mode_i` = 00 (capture), the input `cap_pin_i` passes through two synchronizing flops and then an edge detector. `edge_sel_i` = 01 captures on rising edges, 10 on falling edges and 11 on both; 00 captures nothing. On a capture the channel value takes the counter value from the cycle before the capturing clock, and the channel flag is set. Edges that are not selected leave the value unchanged.
- R3: In capture mode, a bus read of address 0 (upper byte) blocks captures. The block lasts until a bus read of address 1 (lower byte).
- R4: With `mode_i` != 00 and `tov_i` = 0, the clock at which the counter equals the channel value toggles `pin_o` and sets the flag. `pin_o` changes at no other clock.
- R5: In compare mode, a bus write to address 0 blocks compare events. The block lasts until a bus write to address 1.
- R6: With `mode_i` != 00 and `tov_i` = 1, the wrap event drives `pin_o` to `pol_i` (the active level), and a compare match drives it to the inverse of `pol_i`. When both happen at the same clock, the wrap wins.
- R7: `max_duty_i` is copied into a shadow bit only at the wrap event. While the shadow bit is 1 and `tov_i` = 1, a compare match drives `pin_o` to `pol_i`, so the pin holds the active level continuously. The pin is high for `pol_i` = 1 and low for `pol_i` = 0. Setting or clearing `max_duty_i` therefore takes effect in the period after the change.
- R8: The flag `flag_o` is cleared by a bus read of address 2 while it is 1, followed by a bus write to address 2 with bit 0 = 0. A capture or compare event in the clearing cycle wins over the clear.
- R9: `rdata_o` is combinational from `addr_i`: address 0 gives value bits 15:8, address 1 gives bits 7:0, address 2 gives the flag in bit 0 with zeros above, and other addresses give 0. Writes to addresses 0 and 1 load the matching byte in either mode.
- R10: After reset, `pin_o` and `flag_o` are 0. The channel value has no defined reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| modulus_i | input | 16 | Last counter value before wrap |
| mode_i | input | 2 | 00 capture, otherwise compare |
| edge_sel_i | input | 2 | Capture edge select |
| tov_i | input | 1 | Drive pin to active level on wrap (PWM) |
| pol_i | input | 1 | PWM active level |
| max_duty_i | input | 1 | Full-duty request |
| cap_pin_i | input | 1 | Asynchronous capture input |
| addr_i | input | 2 | Bus register address |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data |
| cnt_o | output | 16 | Counter value |
| pin_o | output | 1 | Channel output pin |
| flag_o | output | 1 | Channel event flag |

## Verification
Counter, pin and flag respond at the first clock edge after the condition that causes them. A change on the capture input reaches the channel value at the third edge after it. A full-duty change shows first in the period that follows the next wrap. The bench keeps a reference model that advances on each rising edge. It compares counter, pin and flag on each falling edge, half a cycle after every registered update. Bus reads are sampled 1 ns after the address is set, since read data is combinational. The duty checks count pin-high cycles over exactly one period, starting at counter value 0.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] ADDR_HI   = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic rd_hi;
    logic rd_lo;
  } byte_acc_t;
endpackage

// File: rtl/tim_chan_cnt.sv
module tim_chan_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] modulus_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = (cnt_q == modulus_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ovf_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == modulus_i) |=> (cnt_o == '0)); // R1
endmodule

// File: rtl/tim_chan_edge.sv
module tim_chan_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise  = sync_q[SYNC_N-1] & ~prev_q;
  assign fall  = ~sync_q[SYNC_N-1] & prev_q;
  assign hit_o = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);
endmodule

// File: rtl/tim_chan_val.sv
module tim_chan_val
  import tim_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  byte_acc_t           acc_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                cap_mode_i,
  input  logic                hit_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [CNT_W-1:0]    val_o,
  output logic                cap_fire_o,
  output logic                cmp_fire_o
);
  logic [CNT_W-1:0] val_q;
  logic             lock_q;
  logic             lock_set, lock_clr;

  assign cap_fire_o = cap_mode_i & hit_i & ~lock_q;
  assign cmp_fire_o = ~cap_mode_i & (cnt_i == val_q) & ~lock_q;
  assign lock_set   = cap_mode_i ? acc_i.rd_hi : acc_i.wr_hi;
  assign lock_clr   = cap_mode_i ? acc_i.rd_lo : acc_i.wr_lo;
  assign val_o      = val_q;

  // channel value has no reset
  always_ff @(posedge clk_i) begin
    if (acc_i.wr_hi) val_q[CNT_W-1 -: BYTE_W] <= wdata_i;
    if (acc_i.wr_lo) val_q[BYTE_W-1:0]        <= wdata_i;
    if (!acc_i.wr_hi && !acc_i.wr_lo && cap_fire_o) val_q <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
    else if (lock_clr) lock_q <= 1'b0;
  end

  AST_CAP_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && cap_mode_i && !acc_i.wr_hi && !acc_i.wr_lo) |=> $stable(val_q)); // R3
endmodule

// File: rtl/tim_chan_out.sv
module tim_chan_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_mode_i,
  input  logic tov_i,
  input  logic pol_i,
  input  logic max_duty_i,
  input  logic ovf_i,
  input  logic match_i,
  output logic pin_o
);
  logic pin_q, max_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q    <= 1'b0;
      max_sh_q <= 1'b0;
    end else begin
      if (ovf_i) max_sh_q <= max_duty_i;
      if (cmp_mode_i) begin
        if (tov_i) begin
          if (ovf_i)        pin_q <= pol_i;
          else if (match_i) pin_q <= max_sh_q ? pol_i : ~pol_i;
        end else if (match_i) begin
          pin_q <= ~pin_q;
        end
      end
    end
  end

  assign pin_o = pin_q;

  AST_OVF_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && tov_i && cmp_mode_i) |=> (pin_o == $past(pol_i))); // R6
  AST_MAX_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i |=> $stable(max_sh_q)); // R7
  AST_MAX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && max_sh_q && tov_i && cmp_mode_i) |=> (pin_o == $past(pol_i))); // R7
  AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && !ovf_i) |=> $stable(pin_o)); // R4
endmodule

// File: rtl/tim_chan.sv
module tim_chan
  import tim_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  modulus_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              tov_i,
  input  logic              pol_i,
  input  logic              max_duty_i,
  input  logic              cap_pin_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pin_o,
  output logic              flag_o
);
  logic             cmp_mode, ovf, hit, cap_fire, cmp_fire;
  logic [CNT_W-1:0] val;
  byte_acc_t        acc;
  logic             flag_q, arm_q, flag_set, flag_clr;

  assign cmp_mode  = |mode_i;
  assign acc.wr_hi = wr_en_i & (addr_i == ADDR_HI);
  assign acc.wr_lo = wr_en_i & (addr_i == ADDR_LO);
  assign acc.rd_hi = rd_en_i & (addr_i == ADDR_HI);
  assign acc.rd_lo = rd_en_i & (addr_i == ADDR_LO);

  tim_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .modulus_i(modulus_i), .cnt_o(cnt_o), .ovf_o(ovf)
  );

  tim_chan_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_pin_i), .edge_sel_i(edge_sel_i), .hit_o(hit)
  );

  tim_chan_val #(.CNT_W(CNT_W)) u_val (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .wdata_i(wdata_i),
    .cap_mode_i(~cmp_mode), .hit_i(hit), .cnt_i(cnt_o), .val_o(val),
    .cap_fire_o(cap_fire), .cmp_fire_o(cmp_fire)
  );

  tim_chan_out u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_mode_i(cmp_mode), .tov_i(tov_i), .pol_i(pol_i),
    .max_duty_i(max_duty_i), .ovf_i(ovf), .match_i(cmp_fire), .pin_o(pin_o)
  );

  // flag: read-1 arms, write-0 clears; new event wins
  assign flag_set = cap_fire | cmp_fire;
  assign flag_clr = wr_en_i & (addr_i == ADDR_STAT) & ~wdata_i[0] & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (flag_clr)                                        arm_q <= 1'b0;
      else if (rd_en_i && addr_i == ADDR_STAT && flag_q)   arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_HI:   rdata_o = val[CNT_W-1 -: BYTE_W];
      ADDR_LO:   rdata_o = val[BYTE_W-1:0];
      ADDR_STAT: rdata_o = {{(BYTE_W-1){1'b0}}, flag_q};
      default:   rdata_o = '0;
    endcase
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !flag_set) |=> !flag_o); // R8
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set |=> flag_o); // R8
endmodule

// File: tb/tim_chan_bench.sv
`timescale 1ns/1ps
module tim_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] modulus = 16'd19;
  logic [1:0]  mode = 2'b00, edge_sel = 2'b00, addr = 2'd0;
  logic        tov = 1'b0, pol = 1'b0, max_duty = 1'b0, cap_pin = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [15:0] cnt;
  logic        pin, flag;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tim_chan u_tim_chan (
    .clk_i(clk), .rst_ni(rst_n), .modulus_i(modulus), .mode_i(mode), .edge_sel_i(edge_sel),
    .tov_i(tov), .pol_i(pol), .max_duty_i(max_duty), .cap_pin_i(cap_pin), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .cnt_o(cnt),
    .pin_o(pin), .flag_o(flag)
  );

  // reference model
  logic [15:0] m_cnt = 0, m_val = 0;
  logic m_s1 = 0, m_s2 = 0, m_p = 0, m_lock = 0, m_pin = 0, m_max = 0, m_flag = 0, m_arm = 0;

  always @(posedge clk) begin : model
    logic ovf, match, cap, cmp, clr, rise, fall;
    if (!rst_n) begin
      m_cnt = 0; m_s1 = 0; m_s2 = 0; m_p = 0; m_lock = 0; m_pin = 0; m_max = 0;
      m_flag = 0; m_arm = 0;
    end else begin
      cmp   = (mode != 2'b00);
      ovf   = (m_cnt == modulus);
      match = cmp && (m_cnt == m_val) && !m_lock;
      rise  = m_s2 && !m_p;
      fall  = !m_s2 && m_p;
      cap   = !cmp && !m_lock && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
      clr   = wr_en && addr == 2'd2 && !wdata[0] && m_arm;
      if (wr_en && addr == 2'd0) m_val[15:8] = wdata;
      if (wr_en && addr == 2'd1) m_val[7:0] = wdata;
      if (!(wr_en && addr <= 2'd1) && cap) m_val = m_cnt;
      if (cmp ? (wr_en && addr == 2'd0) : (rd_en && addr == 2'd0)) m_lock = 1;
      else if (cmp ? (wr_en && addr == 2'd1) : (rd_en && addr == 2'd1)) m_lock = 0;
      if (cmp) begin
        if (tov) begin
          if (ovf) m_pin = pol;
          else if (match) m_pin = m_max ? pol : !pol;
        end else if (match) m_pin = !m_pin;
      end
      if (ovf) m_max = max_duty;
      if (clr) m_arm = 0;
      else if (rd_en && addr == 2'd2 && m_flag) m_arm = 1;
      if (cap || match) m_flag = 1;
      else if (clr) m_flag = 0;
      m_p = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
      m_cnt = ovf ? 16'd0 : m_cnt + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cnt !== m_cnt || pin !== m_pin || flag !== m_flag) begin
        errors++;
        $display("FAIL R1 R4 R6 R7 R8 cycle compare: cnt=%0d pin=%0b flag=%0b expected cnt=%0d pin=%0b flag=%0b",
                 cnt, pin, flag, m_cnt, m_pin, m_flag);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    @(negedge clk);
    while (cnt != v) @(negedge clk);
  endtask

  task automatic high_count(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (pin) n++;
      @(negedge clk);
    end
  endtask

  task automatic read_val(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(2'd0, h);
    bus_rd(2'd1, l);
    v = {h, l};
  endtask

  task automatic clear_flag();
    logic [7:0] s;
    bus_rd(2'd2, s);
    bus_wr(2'd2, 8'h00);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0]  d;
    logic [15:0] v, w;
    logic        p0;
    int          n;
    idle(3);
    chk("R10 reset cnt", cnt, 16'd0);
    chk("R10 reset pin", {15'd0, pin}, 16'd0);
    chk("R10 reset flag", {15'd0, flag}, 16'd0);
    rst_n = 1'b1;

    // R1 wrap
    wait_cnt(16'd19); idle(1);
    chk("R1 wrap to zero", cnt, 16'd0);

    // R9 byte access
    bus_wr(2'd0, 8'h12); bus_wr(2'd1, 8'h34);
    bus_rd(2'd0, d); chk("R9 high byte", {8'd0, d}, 16'h0012);
    bus_rd(2'd1, d); chk("R9 low byte", {8'd0, d}, 16'h0034);
    bus_rd(2'd2, d); chk("R9 status byte", {8'd0, d}, 16'h0000);
    bus_rd(2'd3, d); chk("R9 unused address", {8'd0, d}, 16'h0000);

    // R2 capture edges
    edge_sel = 2'b01;
    cap_pin = 1'b1; idle(6);
    read_val(v); chk("R2 rising capture", v, m_val);
    chk("R2 rising capture changed", {15'd0, v != 16'h1234}, 16'd1);
    chk("R2 flag after capture", {15'd0, flag}, 16'd1);
    clear_flag(); idle(1);
    chk("R8 flag cleared", {15'd0, flag}, 16'd0);
    cap_pin = 1'b0; idle(6);
    read_val(w); chk("R2 falling ignored with rise select", w, v);
    chk("R2 no flag on ignored edge", {15'd0, flag}, 16'd0);
    edge_sel = 2'b10;
    cap_pin = 1'b1; idle(6);
    read_val(w); chk("R2 rising ignored with fall select", w, v);
    cap_pin = 1'b0; idle(6);
    read_val(w); chk("R2 falling capture", w, m_val);
    edge_sel = 2'b11;
    cap_pin = 1'b1; idle(7);
    read_val(v); chk("R2 both: rising", v, m_val);
    cap_pin = 1'b0; idle(9);
    read_val(w); chk("R2 both: falling", w, m_val);
    chk("R2 both: value moved", {15'd0, w != v}, 16'd1);

    // R3 capture lock
    bus_rd(2'd0, d); v = m_val;
    cap_pin = 1'b1; idle(6); cap_pin = 1'b0; idle(6);
    bus_rd(2'd1, d);
    chk("R3 locked high byte", m_val, v);
    chk("R3 locked low byte", {8'd0, d}, {8'd0, v[7:0]});
    cap_pin = 1'b1; idle(8);
    read_val(w); chk("R3 capture after unlock", w, m_val);
    edge_sel = 2'b00; v = w;
    cap_pin = 1'b0; idle(6);
    read_val(w); chk("R2 no edge selected", w, v);
    clear_flag();

    // R4 compare toggle
    mode = 2'b01; tov = 1'b0;
    bus_wr(2'd0, 8'h00); bus_wr(2'd1, 8'h05);
    idle(25); p0 = pin; idle(20);
    chk("R4 one toggle per period", {15'd0, pin}, {15'd0, ~p0});
    chk("R4 flag on match", {15'd0, flag}, 16'd1);
    clear_flag();

    // R5 compare lock
    bus_wr(2'd0, 8'h00); p0 = pin; idle(45);
    chk("R5 no toggle while locked", {15'd0, pin}, {15'd0, p0});
    chk("R5 no flag while locked", {15'd0, flag}, 16'd0);
    bus_wr(2'd1, 8'h05); idle(20);
    chk("R5 toggle after unlock", {15'd0, pin}, {15'd0, ~p0});

    // R6 PWM
    tov = 1'b1; pol = 1'b1;
    bus_wr(2'd0, 8'h00); bus_wr(2'd1, 8'h07); idle(40);
    wait_cnt(16'd0); high_count(n);
    chk("R6 high cycles pol=1", n[15:0], 16'd8);
    pol = 1'b0; idle(40);
    wait_cnt(16'd0); high_count(n);
    chk("R6 high cycles pol=0", n[15:0], 16'd12);
    pol = 1'b1;
    bus_wr(2'd1, 8'h13); idle(40);
    wait_cnt(16'd0); high_count(n);
    chk("R6 wrap wins over match", n[15:0], 16'd20);
    bus_wr(2'd1, 8'h07); idle(40);

    // R7 full-duty override
    wait_cnt(16'd10); max_duty = 1'b1;
    wait_cnt(16'd15);
    chk("R7 set waits for wrap", {15'd0, pin}, 16'd0);
    wait_cnt(16'd0); high_count(n);
    chk("R7 full duty pol=1", n[15:0], 16'd20);
    pol = 1'b0; idle(20);
    wait_cnt(16'd0); high_count(n);
    chk("R7 full duty pol=0", n[15:0], 16'd0);
    pol = 1'b1; idle(20);
    wait_cnt(16'd10); max_duty = 1'b0;
    wait_cnt(16'd15);
    chk("R7 clear waits for wrap", {15'd0, pin}, 16'd1);
    wait_cnt(16'd0); high_count(n);
    chk("R7 normal duty restored", n[15:0], 16'd8);

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule